// File: doc/BRIEF.md
# Two-Output Dual-MAC FIR Filter Engine

This block is a fixed-point finite impulse response filter that works through its coefficient set once for every pair of output samples. A single coefficient is read each cycle and goes to two multiply-accumulate lanes at once. One lane pairs it with the older data sample and the other pairs it with the sample one position newer. After one sweep of `TAPS` cycles, both lanes hold the full sums for y(n) and y(n+1). Each sum is rounded, clipped to the output width and presented on one output port, first y(n) and then y(n+1) on the next cycle.

The caller supplies two new samples, x(n) and x(n+1), with a `start` pulse while the engine is idle. The samples go into a circular history of `TAPS+1` entries that keeps its contents from one pair to the next, so the filter runs over a continuous stream. Coefficients are loaded through a plain write port. The engine accepts a coefficient write while it is idle and ignores one while it is busy, so a sweep always uses a consistent coefficient set.

Top module: `dual_mac_fir`

## Requirements
- R1: During and right after reset, `busy`, `done` and `y_valid` are low and `y_data` is zero. All coefficients and all history entries reset to zero.
- R2: Each output equals the sum over k = 0..TAPS-1 of c(k)·x(m−k), where m is the output's sample index. Samples older than the first sample accepted after reset count as zero. History carries over from one pair to the next.
- R3: A `start` accepted at clock edge E0 makes `y_valid` rise after edge E0+TAPS and stay high for exactly two cycles. `y_data` carries y(n), from `x_first`, in the first of these cycles and y(n+1), from `x_second`, in the second.
- R4: `busy` is high from the edge that accepts `start` until the second output cycle ends. A `start` raised while `busy` is high is ignored: its samples never enter the history.
- R5: `done` is high for exactly one cycle, the cycle that presents y(n+1).
- R6: The full-precision sum is scaled by 2^−FRAC (FRAC = 15 by default) and rounded to nearest. An exact half rounds toward plus infinity, so the scaled value is floor((sum + 2^(FRAC−1)) / 2^FRAC).
- R7: A scaled value that does not fit the signed `OW`-bit output is clipped to 2^(OW−1)−1 or −2^(OW−1).
- R8: When `coef_we` is high at a clock edge while the engine is idle, c(`coef_addr`) takes `coef_wdata`. A coefficient write while `busy` is high is ignored.
- R9: A coefficient write in the same cycle as an accepted `start` already applies to the pair that `start` begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | $clog2(TAPS) | Tap index k to write |
| coef_wdata | input | CW | Signed coefficient value |
| start | input | 1 | Begin a pair; accepted only when idle |
| x_first | input | DW | Signed sample x(n) |
| x_second | input | DW | Signed sample x(n+1) |
| busy | output | 1 | Pair in progress |
| done | output | 1 | Second output of a pair is on `y_data` |
| y_valid | output | 1 | `y_data` holds a result |
| y_data | output | OW | Rounded, clipped signed output |

## Verification
Two pairs of functions can fall in the same cycle. The bench drives a coefficient write in the same cycle as `start`, and the pair's outputs must match a reference that uses the new coefficient. The bench also raises `start` and `coef_we` with junk values partway through a sweep. Because neither input may take effect, the outputs of that pair and of the next pair must match a reference that never saw the junk. Outputs are compared with a bench-side convolution over the full sample history, including exact-half rounding cases and clipping at both ends of the range.

// File: rtl/fir2_pkg.sv
// Shared types for the two-output FIR engine.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package fir2_pkg;

    // Sequencer phases: idle, coefficient sweep, first output, second output.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SWEEP = 2'd1,
        PH_OUT_A = 2'd2,
        PH_OUT_B = 2'd3
    } fir2_phase_e;

endpackage

// File: rtl/fir2_coef_bank.sv
// Coefficient register bank with one write port and one combinational read port.
// Assumes: lock is high whenever a sweep is in flight; writes then are dropped.
module fir2_coef_bank #(
    parameter int TAPS = 8,
    parameter int CW   = 16,
    localparam int KW  = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic                 lock,
    input  logic [KW-1:0]        waddr,
    input  logic signed [CW-1:0] wdata,
    input  logic [KW-1:0]        raddr,
    output logic signed [CW-1:0] rdata
);

    logic signed [CW-1:0] mem [TAPS];

    // Store a coefficient when the engine is idle; clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) mem[i] <= '0;
        end else if (we && !lock) begin
            mem[waddr] <= wdata;
        end
    end

    // Single read path feeding both MAC lanes.
    assign rdata = mem[raddr];

    // R8
    coef_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !lock) |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/fir2_history.sv
// Circular sample history of TAPS+1 entries with two write and two read ports.
// Each push stores two samples; read ports give x(n-k) (older) and x(n+1-k) (newer).
// Assumes: tap index k < TAPS; push only while the sweep is not reading.
module fir2_history #(
    parameter int TAPS = 8,
    parameter int DW   = 16,
    localparam int KW  = (TAPS > 1) ? $clog2(TAPS) : 1,
    localparam int D   = TAPS + 1,
    localparam int PW  = $clog2(D)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic signed [DW-1:0] s_first,
    input  logic signed [DW-1:0] s_second,
    input  logic [KW-1:0]        tap,
    output logic signed [DW-1:0] rd_old,
    output logic signed [DW-1:0] rd_new
);

    localparam logic [PW:0] DEPTH = (PW+1)'(D);

    logic signed [DW-1:0] mem [D];
    logic [PW-1:0]        head;
    logic [PW:0]          w1, w2, r_new, r_old;

    // Wrap a value below 2*D into the range 0..D-1.
    function automatic logic [PW:0] wrap(input logic [PW:0] v);
        return (v >= DEPTH) ? v - DEPTH : v;
    endfunction

    // Write slots for the two incoming samples and read slots for the current tap.
    always_comb begin
        w1    = wrap({1'b0, head} + (PW+1)'(1));
        w2    = wrap({1'b0, head} + (PW+1)'(2));
        r_new = wrap({1'b0, head} + DEPTH - (PW+1)'(tap));
        r_old = wrap({1'b0, head} + DEPTH - (PW+1)'(tap) - (PW+1)'(1));
    end

    // Store a sample pair and move the head to the newest entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < D; i++) mem[i] <= '0;
            head <= '0;
        end else if (push) begin
            mem[w1[PW-1:0]] <= s_first;
            mem[w2[PW-1:0]] <= s_second;
            head            <= w2[PW-1:0];
        end
    end

    assign rd_new = mem[r_new[PW-1:0]];
    assign rd_old = mem[r_old[PW-1:0]];

    // R2
    head_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> ({1'b0, head} < DEPTH));

endmodule

// File: rtl/fir2_mac.sv
// One multiply-accumulate lane with guard bits; clear has priority over accumulate.
// Assumes: AW is wide enough for TAPS full-scale products.
module fir2_mac #(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int AW = 36
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 en,
    input  logic signed [CW-1:0] coef,
    input  logic signed [DW-1:0] smp,
    output logic signed [AW-1:0] acc
);

    logic signed [DW+CW-1:0] prod;

    // Full-precision product of coefficient and sample.
    assign prod = coef * smp;

    // Clear at the start of a pair, otherwise add one product per sweep cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) acc <= '0;
        else if (en)         acc <= acc + AW'(prod);
    end

    // R2
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc == '0));

endmodule

// File: rtl/dual_mac_fir.sv
// Two-output FIR engine: one coefficient sweep of TAPS cycles fills two MAC lanes,
// then y(n) and y(n+1) are rounded, clipped and presented on consecutive cycles.
// Assumes: start is honoured only when idle; coefficient writes only when idle.
module dual_mac_fir #(
    parameter int TAPS = 8,
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int OW   = 16,
    parameter int FRAC = 15,
    localparam int KW  = (TAPS > 1) ? $clog2(TAPS) : 1,
    localparam int AW  = DW + CW + KW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 coef_we,
    input  logic [KW-1:0]        coef_addr,
    input  logic signed [CW-1:0] coef_wdata,
    input  logic                 start,
    input  logic signed [DW-1:0] x_first,
    input  logic signed [DW-1:0] x_second,
    output logic                 busy,
    output logic                 done,
    output logic                 y_valid,
    output logic signed [OW-1:0] y_data
);
    import fir2_pkg::*;

    localparam int LANES = 2;
    localparam logic signed [AW:0] HALF = $signed((AW+1)'(1) << (FRAC-1));
    localparam logic signed [AW:0] MAXV = $signed((AW+1)'((64'sd1 <<< (OW-1)) - 1));
    localparam logic signed [AW:0] MINV = -MAXV - (AW+1)'(1);
    localparam logic [KW-1:0]      LAST = KW'(TAPS - 1);

    fir2_phase_e          phase;
    logic [KW-1:0]        tap;
    logic                 accept;
    logic signed [CW-1:0] coef;
    logic signed [DW-1:0] lane_smp [LANES];
    logic signed [AW-1:0] lane_acc [LANES];

    // Scale by 2^-FRAC with round-half-up, then clip to the output range.
    function automatic logic signed [OW-1:0] round_clip(input logic signed [AW-1:0] a);
        logic signed [AW:0] r;
        r = ($signed({a[AW-1], a}) + HALF) >>> FRAC;
        if (r > MAXV)      return MAXV[OW-1:0];
        else if (r < MINV) return MINV[OW-1:0];
        else               return r[OW-1:0];
    endfunction

    assign accept = start && (phase == PH_IDLE);
    assign busy   = (phase != PH_IDLE);

    // Phase sequencer and tap counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            tap   <= '0;
        end else begin
            case (phase)
                PH_IDLE:  if (start) begin phase <= PH_SWEEP; tap <= '0; end
                PH_SWEEP: if (tap == LAST) phase <= PH_OUT_A;
                          else             tap   <= tap + KW'(1);
                PH_OUT_A: phase <= PH_OUT_B;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    fir2_coef_bank #(.TAPS(TAPS), .CW(CW)) u_coef (
        .clk(clk), .rst_n(rst_n), .we(coef_we), .lock(busy),
        .waddr(coef_addr), .wdata(coef_wdata), .raddr(tap), .rdata(coef)
    );

    fir2_history #(.TAPS(TAPS), .DW(DW)) u_hist (
        .clk(clk), .rst_n(rst_n), .push(accept),
        .s_first(x_first), .s_second(x_second), .tap(tap),
        .rd_old(lane_smp[0]), .rd_new(lane_smp[1])
    );

    // Lane 0 builds y(n) from x(n-k); lane 1 builds y(n+1) from x(n+1-k).
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fir2_mac #(.DW(DW), .CW(CW), .AW(AW)) u_mac (
            .clk(clk), .rst_n(rst_n), .clear(accept),
            .en(phase == PH_SWEEP), .coef(coef),
            .smp(lane_smp[g]), .acc(lane_acc[g])
        );
    end

    // Present lane 0 then lane 1; drive zero when no result is shown.
    always_comb begin
        y_valid = (phase == PH_OUT_A) || (phase == PH_OUT_B);
        done    = (phase == PH_OUT_B);
        if (phase == PH_OUT_A)      y_data = round_clip(lane_acc[0]);
        else if (phase == PH_OUT_B) y_data = round_clip(lane_acc[1]);
        else                        y_data = '0;
    end

    // R5
    done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> y_valid);

    // R3
    pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_valid && !done) |=> (y_valid && done));

    // R4
    busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R3
    out_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !y_valid && !busy);

endmodule

// File: tb/dual_mac_fir_tb.sv
// Bench for dual_mac_fir: a table of sample pairs walked by one loop against a
// bench-side convolution, then directed reset, rounding, clipping and overlap tests.
module dual_mac_fir_tb;

    localparam int TAPS = 8;
    localparam int DW   = 16;
    localparam int CW   = 16;
    localparam int OW   = 16;
    localparam int FRAC = 15;
    localparam int KW   = $clog2(TAPS);
    localparam int NVEC = 6;

    // Stimulus vectors: {x_first, x_second}; expected values come from ref_y.
    localparam logic [31:0] STIM [NVEC] = '{
        32'h0100_0200, 32'hFF00_0080, 32'h7FFF_8000,
        32'h0001_FFFF, 32'h1234_EDCB, 32'h0000_0000
    };
    localparam int COEF_SET [TAPS] = '{1000, -2000, 3000, 16384, -500, 250, 7, -32768};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 coef_we = 1'b0;
    logic [KW-1:0]        coef_addr = '0;
    logic signed [CW-1:0] coef_wdata = '0;
    logic                 start = 1'b0;
    logic signed [DW-1:0] x_first = '0;
    logic signed [DW-1:0] x_second = '0;
    logic                 busy, done, y_valid;
    logic signed [OW-1:0] y_data;

    int   errors = 0;
    int   checks = 0;
    int   hist [$];
    int   cref [TAPS];

    always #4 clk = ~clk;

    dual_mac_fir #(.TAPS(TAPS), .DW(DW), .CW(CW), .OW(OW), .FRAC(FRAC)) u_dut (
        .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_addr(coef_addr),
        .coef_wdata(coef_wdata), .start(start), .x_first(x_first),
        .x_second(x_second), .busy(busy), .done(done), .y_valid(y_valid),
        .y_data(y_data)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference output for history index m: convolution, round-half-up, clip (R2, R6, R7).
    function automatic longint ref_y(input int m);
        longint s = 0;
        longint r;
        for (int k = 0; k < TAPS; k++)
            if (m - k >= 0) s += longint'(cref[k]) * longint'(hist[m - k]);
        r = (s + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
        if (r > (64'sd1 <<< (OW - 1)) - 1) r = (64'sd1 <<< (OW - 1)) - 1;
        if (r < -(64'sd1 <<< (OW - 1)))    r = -(64'sd1 <<< (OW - 1));
        return r;
    endfunction

    task automatic write_coef(input int k, input int v);
        @(negedge clk);
        coef_we = 1'b1; coef_addr = KW'(k); coef_wdata = CW'(v);
        @(negedge clk);
        coef_we = 1'b0;
        cref[k] = v;
    endtask

    // One pair. Optional same-cycle coefficient write, optional junk pokes mid-sweep.
    task automatic run_pair(input int a, input int b, input bit wr_now, input int wk,
                            input int wv, input bit poke, input string tag);
        longint e0, e1;
        @(negedge clk);
        start = 1'b1; x_first = DW'(a); x_second = DW'(b);
        if (wr_now) begin
            coef_we = 1'b1; coef_addr = KW'(wk); coef_wdata = CW'(wv);
            cref[wk] = wv;
        end
        hist.push_back(int'($signed(DW'(a))));
        hist.push_back(int'($signed(DW'(b))));
        e0 = ref_y(hist.size() - 2);
        e1 = ref_y(hist.size() - 1);
        @(negedge clk);
        start = 1'b0; coef_we = 1'b0;
        chk({tag, " R4 busy after start"}, busy, 1);
        for (int j = 1; j < TAPS; j++) begin
            if (poke && j == 2) begin
                start = 1'b1; x_first = 16'sh5A5A; x_second = -16'sh1111;
                coef_we = 1'b1; coef_addr = '0; coef_wdata = 16'sh7777;
            end
            @(negedge clk);
            start = 1'b0; coef_we = 1'b0;
        end
        chk({tag, " R3 no output before sweep ends"}, y_valid, 0);
        @(negedge clk);
        chk({tag, " R3 first valid"}, y_valid, 1);
        chk({tag, " R5 done low on y(n)"}, done, 0);
        chk({tag, " R2 y(n)"}, y_data, e0);
        @(negedge clk);
        chk({tag, " R3 second valid"}, y_valid, 1);
        chk({tag, " R5 done on y(n+1)"}, done, 1);
        chk({tag, " R2 y(n+1)"}, y_data, e1);
        @(negedge clk);
        chk({tag, " R4 idle after pair"}, busy, 0);
        chk({tag, " R3 valid ends"}, y_valid, 0);
    endtask

    // Watchdog: a hung run counts as one failed check and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < TAPS; k++) cref[k] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy in reset", busy, 0);
        chk("R1 valid in reset", y_valid, 0);
        chk("R1 done in reset", done, 0);
        chk("R1 data in reset", y_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        // R1: zero coefficients give zero output
        run_pair(1234, -999, 1'b0, 0, 0, 1'b0, "R1 zero coefs");

        // R8 load coefficient set while idle
        for (int k = 0; k < TAPS; k++) write_coef(k, COEF_SET[k]);
        // R2 table walk
        for (int v = 0; v < NVEC; v++)
            run_pair(int'($signed(STIM[v][31:16])), int'($signed(STIM[v][15:0])),
                     1'b0, 0, 0, 1'b0, "R2 table");

        // R4 / R8: start and coef write during sweep are ignored
        run_pair(300, -700, 1'b0, 0, 0, 1'b1, "R4 R8 poke");
        run_pair(50, 60, 1'b0, 0, 0, 1'b0, "R4 R8 after poke");

        // R9: coefficient write together with start applies at once
        run_pair(4000, -4000, 1'b1, 3, -12000, 1'b0, "R9 same-cycle write");

        // R6 rounding: single unit tap
        for (int k = 0; k < TAPS; k++) write_coef(k, 0);
        write_coef(0, 1);
        run_pair(16384, 16383, 1'b0, 0, 0, 1'b0, "R6 half up");
        run_pair(-16384, -16385, 1'b0, 0, 0, 1'b0, "R6 negative half");
        chk("R6 literal -16385 -> -1", ref_y(hist.size() - 1), -1);

        // R7 clipping at both ends
        for (int k = 0; k < TAPS; k++) write_coef(k, 32767);
        for (int p = 0; p < 4; p++) run_pair(32767, 32767, 1'b0, 0, 0, 1'b0, "R7 high");
        chk("R7 literal high clip", ref_y(hist.size() - 1), 32767);
        for (int p = 0; p < 4; p++) run_pair(-32768, -32768, 1'b0, 0, 0, 1'b0, "R7 low");
        chk("R7 literal low clip", ref_y(hist.size() - 1), -32768);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule